// File: doc/BRIEF.md
# Configurable Synchronous Serial Port (Master or Slave)

This block is a four-wire synchronous serial port. It can run as the clock-driving master or as a slave that follows an external clock. The four signals are a serial clock, a master-to-slave data line, a slave-to-master data line and an active-low slave select. Each signal is brought out as separate input, output and output-enable pins, so the pad ring can build the bidirectional pins. One character is exchanged in both directions at once. The character length can be set from one to eight bits. A polarity bit and a phase bit together select one of four clocking schemes.

Software reaches the port through byte-wide registers on a 16-bit bus. In master mode, writing the transmit register starts a character. The character then runs at a rate set by a 7-bit divider value. In slave mode, the transmit register is preloaded and shifted out under the external clock while the select line is low. At the end of every character a sticky completion flag is set. The flag can be polled, or it can raise the interrupt output. The transmit side can be switched off, so that the port only receives.

Top module: `spi_port`

## Requirements
- R1: The LEN register (offset 1, bits 2:0) holds length−1, giving characters of 1 to 8 bits. Data goes out most significant bit first, taken from the top bits of the transmit register (offset 4). After a character completes, the receive register (offset 5) holds the received bits right-justified, with unused upper bits at zero.
- R2: CTRL (offset 0) bit 1 sets the clock idle level. With bit 2 clear, data is sampled on the first (leading) clock edge and changed on the trailing edge. With bit 2 set, data is changed on the leading edge and sampled on the trailing edge. A master and a slave with the same setting exchange characters correctly in all four combinations.
- R3: In master mode (CTRL bit 0 set), the serial clock period is (B+1) system clocks for a BAUD register (offset 2) value B from 3 to 127. Values 0 to 2 give a period of 4.
- R4: A single character exchanges data in both directions at the same time. The master receives the slave's character, and the slave receives the master's character.
- R5: When CTRL bit 3 (transmit enable) is clear, the port never enables its data output. It still receives, and the peer then sees the idle-high line (all ones).
- R6: A slave whose select input is high ignores the serial clock, keeps its data output disabled, and neither completes a character nor changes its receive register.
- R7: Bus reads return zero in bits 15:8. Writes to bits 15:8 have no effect.
- R8: STAT (offset 3) bit 0 is set when a character completes. Writing 1 to that bit clears it. The irq output equals this flag ANDed with CTRL bit 4. STAT bit 1 shows a transfer in progress.
- R9: A master drives its select output low for the whole character. Whenever no character is in progress, it holds the serial clock at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data (upper byte ignored) |
| bus_rdata | output | 16 | Read data (upper byte zero) |
| irq | output | 1 | Completion interrupt |
| sclk_in | input | 1 | Serial clock from the line (slave) |
| sclk_out | output | 1 | Serial clock driven by master |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_in | input | 1 | Master-to-slave data input (slave) |
| mosi_out | output | 1 | Master-to-slave data output (master) |
| mosi_oe | output | 1 | Master-to-slave data output enable |
| miso_in | input | 1 | Slave-to-master data input (master) |
| miso_out | output | 1 | Slave-to-master data output (slave) |
| miso_oe | output | 1 | Slave-to-master data output enable |
| ste_n_in | input | 1 | Slave select input, active low |
| ste_n_out | output | 1 | Slave select driven by master |
| ste_n_oe | output | 1 | Slave select output enable |

## Verification
A wrong bit counter or a slipped shift register shows up at the ports within one character. The receive register then holds rotated or truncated data, or the completion flag rises one clock edge early or late, and the line monitor sees a clock pulse too many or too few under a low select. A wrong edge choice for a clock mode corrupts the received character in that mode only. That is why every mode is looped back between a master and a slave. A divider fault appears in the first serial clock period that is measured.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int CHAR_W = 8;
  localparam int BUS_W  = 16;
  localparam int REG_W  = 8;
  localparam int BAUD_W = 7;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = $clog2(CHAR_W);
  localparam int CNT_W  = $clog2(CHAR_W + 1);
  localparam int DIV_W  = BAUD_W + 1;
  localparam int MIN_DIV = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_LEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_BAUD = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_TX   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_RX   = 3'd5;

  typedef struct packed {
    logic irq_en;
    logic tx_en;
    logic cpha;
    logic cpol;
    logic master;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              done,
  input  logic              busy,
  input  logic [CHAR_W-1:0] rxbuf,
  output ctrl_t             ctrl,
  output logic [LEN_W-1:0]  len_m1,
  output logic [BAUD_W-1:0] baud,
  output logic [CHAR_W-1:0] txbuf,
  output logic              tx_load,
  output logic              flag,
  output logic [BUS_W-1:0]  rdata
);
  ctrl_t             ctrl_n;
  logic [LEN_W-1:0]  len_n;
  logic [BAUD_W-1:0] baud_n;
  logic [CHAR_W-1:0] tx_n;
  logic              flag_n;
  logic [REG_W-1:0]  rd_byte;

  assign tx_load = wr && (addr == OFS_TX);

  always_comb begin
    ctrl_n = ctrl;
    len_n  = len_m1;
    baud_n = baud;
    tx_n   = txbuf;
    flag_n = flag;
    if (wr) begin
      case (addr)
        OFS_CTRL: ctrl_n = ctrl_t'(wdata[CTRL_W-1:0]);
        OFS_LEN:  len_n  = wdata[LEN_W-1:0];
        OFS_BAUD: baud_n = wdata[BAUD_W-1:0];
        OFS_STAT: if (wdata[0]) flag_n = 1'b0;
        OFS_TX:   tx_n   = wdata[CHAR_W-1:0];
        default:  ;
      endcase
    end
    if (done) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      len_m1 <= '0;
      baud   <= '0;
      txbuf  <= '0;
      flag   <= 1'b0;
    end else begin
      ctrl   <= ctrl_n;
      len_m1 <= len_n;
      baud   <= baud_n;
      txbuf  <= tx_n;
      flag   <= flag_n;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rd_byte = REG_W'(ctrl);
      OFS_LEN:  rd_byte = REG_W'(len_m1);
      OFS_BAUD: rd_byte = REG_W'(baud);
      OFS_STAT: rd_byte = REG_W'({busy, flag});
      OFS_RX:   rd_byte = REG_W'(rxbuf);
      default:  rd_byte = '0;
    endcase
    rdata = {{(BUS_W-REG_W){1'b0}}, rd_byte};
  end
endmodule

// File: rtl/spi_port_baud.sv
module spi_port_baud
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              lead,
  output logic              trail
);
  logic [DIV_W-1:0] div, half, cnt_q, cnt_n;

  always_comb begin
    div   = (baud < BAUD_W'(MIN_DIV - 1)) ? DIV_W'(MIN_DIV) : DIV_W'(baud) + DIV_W'(1);
    half  = div >> 1;
    lead  = run && (cnt_q == half - DIV_W'(1));
    trail = run && (cnt_q == div - DIV_W'(1));
    if (!run || trail) cnt_n = '0;
    else               cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              is_master,
  input  logic              active,
  input  logic              lead,
  input  logic              trail,
  input  logic              din,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              tx_load,
  input  logic [CHAR_W-1:0] tx_wdata,
  input  logic [CHAR_W-1:0] txbuf,
  output logic              dout,
  output logic              done,
  output logic              mid,
  output logic [CHAR_W-1:0] rxbuf
);
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_nx, len_c;
  logic [CHAR_W-1:0] tx_q, tx_n, rx_q, rx_n, rx_nx, rxb_n;
  logic              first_q, first_n, samp, shft;

  always_comb begin
    samp   = cpha ? trail : lead;
    shft   = cpha ? (lead && !first_q) : trail;
    cnt_nx = cnt_q + CNT_W'(samp);
    len_c  = CNT_W'(len_m1) + CNT_W'(1);
    done   = active && (is_master ? trail : samp) && (cnt_nx == len_c);
    rx_nx  = samp ? {rx_q[CHAR_W-2:0], din} : rx_q;
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    first_n = first_q;
    rxb_n   = rxbuf;
    if (!active || done) begin
      cnt_n   = '0;
      rx_n    = '0;
      first_n = 1'b1;
      tx_n    = tx_load ? tx_wdata : txbuf;
      if (done) rxb_n = rx_nx;
    end else begin
      cnt_n = cnt_nx;
      rx_n  = rx_nx;
      if (lead) first_n = 1'b0;
      if (shft) tx_n = {tx_q[CHAR_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      first_q <= 1'b1;
      rxbuf   <= '0;
    end else begin
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      first_q <= first_n;
      rxbuf   <= rxb_n;
    end
  end

  assign dout = tx_q[CHAR_W-1];
  assign mid  = (cnt_q != '0);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ste_n_in,
  output logic              ste_n_out,
  output logic              ste_n_oe
);
  logic [1:0]        rst_sy;
  logic              rst_i;
  ctrl_t             ctrl;
  logic [LEN_W-1:0]  len_m1;
  logic [BAUD_W-1:0] baud;
  logic [CHAR_W-1:0] txbuf, rxbuf;
  logic              tx_load, flag, done, mid, dout;
  logic              busy_q, busy_n, sclk_q, sclk_n;
  logic              m_lead, m_trail, s_lead, s_trail;
  logic              ev_lead, ev_trail, active, din, ste_n_s;
  logic [2:0]        sclk_sy, ste_sy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= '0;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_i = rst_sy[1];

  spi_port_regs u_regs (
    .clk(clk), .rst_n(rst_i), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .done(done), .busy(busy_q | mid), .rxbuf(rxbuf), .ctrl(ctrl), .len_m1(len_m1),
    .baud(baud), .txbuf(txbuf), .tx_load(tx_load), .flag(flag), .rdata(bus_rdata)
  );

  spi_port_baud u_baud (
    .clk(clk), .rst_n(rst_i), .run(busy_q), .baud(baud),
    .lead(m_lead), .trail(m_trail)
  );

  // Slave side: line clock and select pass through synchronisers; the select
  // path is one stage longer so the final trailing edge is seen while selected.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sclk_sy <= '0;
      ste_sy  <= '1;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk_in};
      ste_sy  <= {ste_sy[1:0], ste_n_in};
    end
  end

  always_comb begin
    ste_n_s  = ste_sy[2];
    s_lead   = (sclk_sy[2] == ctrl.cpol) && (sclk_sy[1] != ctrl.cpol);
    s_trail  = (sclk_sy[2] != ctrl.cpol) && (sclk_sy[1] == ctrl.cpol);
    ev_lead  = ctrl.master ? m_lead  : s_lead;
    ev_trail = ctrl.master ? m_trail : s_trail;
    active   = ctrl.master ? busy_q  : !ste_n_s;
    din      = ctrl.master ? miso_in : mosi_in;
  end

  spi_port_shift u_shift (
    .clk(clk), .rst_n(rst_i), .cpha(ctrl.cpha), .is_master(ctrl.master),
    .active(active), .lead(ev_lead), .trail(ev_trail), .din(din), .len_m1(len_m1),
    .tx_load(tx_load), .tx_wdata(bus_wdata[CHAR_W-1:0]), .txbuf(txbuf),
    .dout(dout), .done(done), .mid(mid), .rxbuf(rxbuf)
  );

  always_comb begin
    busy_n = busy_q;
    if (!ctrl.master)            busy_n = 1'b0;
    else if (done)               busy_n = 1'b0;
    else if (tx_load && !busy_q) busy_n = 1'b1;
    if (!ctrl.master || !busy_q)  sclk_n = ctrl.cpol;
    else if (m_lead || m_trail)   sclk_n = !sclk_q;
    else                          sclk_n = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      sclk_q <= sclk_n;
    end
  end

  assign sclk_out  = sclk_q;
  assign sclk_oe   = ctrl.master;
  assign ste_n_out = !busy_q;
  assign ste_n_oe  = ctrl.master;
  assign mosi_out  = dout;
  assign mosi_oe   = ctrl.master && ctrl.tx_en;
  assign miso_out  = dout;
  assign miso_oe   = !ctrl.master && ctrl.tx_en && !ste_n_s;
  assign irq       = flag && ctrl.irq_en;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_rdata,
  input logic        mosi_oe,
  input logic        miso_oe,
  input logic        sclk_out,
  input logic        ste_n_out,
  input logic        c_master,
  input logic        c_cpol,
  input logic        c_txen,
  input logic        ste_n_s,
  input logic        done,
  input logic        flag
);
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15:8] == 8'h00);

  assert_tx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !c_txen |-> (!mosi_oe && !miso_oe));

  assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_master && ste_n_s) |-> !miso_oe);

  assert_idle_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_master && ste_n_out && $past(ste_n_out) && $stable(c_cpol) && $stable(c_master))
      |-> (sclk_out == c_cpol));

  assert_flag_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .mosi_oe(mosi_oe),
  .miso_oe(miso_oe), .sclk_out(sclk_out), .ste_n_out(ste_n_out),
  .c_master(ctrl.master), .c_cpol(ctrl.cpol), .c_txen(ctrl.tx_en),
  .ste_n_s(ste_n_s), .done(done), .flag(flag)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  m_addr, p_addr;
  logic        m_wr, p_wr, ste_block;
  logic [15:0] m_wd, p_wd, m_rd, p_rd;
  logic m_irq, m_sclk, m_sclk_oe, m_mosi, m_mosi_oe, m_miso, m_miso_oe, m_ste, m_ste_oe;
  logic p_irq, p_sclk, p_sclk_oe, p_mosi, p_mosi_oe, p_miso, p_miso_oe, p_ste, p_ste_oe;
  logic line_mosi, line_miso, line_ste;
  int   n_checks = 0, n_fail = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_mosi = m_mosi_oe ? m_mosi : 1'b1;
  assign line_miso = p_miso_oe ? p_miso : 1'b1;
  assign line_ste  = m_ste | ste_block;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_wr(m_wr), .bus_wdata(m_wd),
    .bus_rdata(m_rd), .irq(m_irq), .sclk_in(m_sclk), .sclk_out(m_sclk), .sclk_oe(m_sclk_oe),
    .mosi_in(line_mosi), .mosi_out(m_mosi), .mosi_oe(m_mosi_oe), .miso_in(line_miso),
    .miso_out(m_miso), .miso_oe(m_miso_oe), .ste_n_in(1'b1), .ste_n_out(m_ste),
    .ste_n_oe(m_ste_oe)
  );

  spi_port peer (
    .clk(clk), .rst_n(rst_n), .bus_addr(p_addr), .bus_wr(p_wr), .bus_wdata(p_wd),
    .bus_rdata(p_rd), .irq(p_irq), .sclk_in(m_sclk), .sclk_out(p_sclk), .sclk_oe(p_sclk_oe),
    .mosi_in(line_mosi), .mosi_out(p_mosi), .mosi_oe(p_mosi_oe), .miso_in(line_miso),
    .miso_out(p_miso), .miso_oe(p_miso_oe), .ste_n_in(line_ste), .ste_n_out(p_ste),
    .ste_n_oe(p_ste_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    if (sel) begin p_addr = a; p_wd = d; p_wr = 1'b1; end
    else     begin m_addr = a; m_wd = d; m_wr = 1'b1; end
    @(negedge clk);
    m_wr = 1'b0; p_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    if (sel) begin p_addr = a; #1 d = p_rd; end
    else     begin m_addr = a; #1 d = m_rd; end
  endtask

  function automatic logic [7:0] exp_rx(input logic [7:0] data, input int len, input bit en);
    logic [7:0] mask = 8'((9'd1 << len) - 9'd1);
    return en ? (data >> (8 - len)) : mask;
  endfunction

  task automatic setup(input logic [1:0] mode, input int len, input int baud,
                       input bit mten, input bit sten, input bit irqen);
    wr(0, 3'd0, {11'd0, irqen, mten, mode[0], mode[1], 1'b1});
    wr(1, 3'd0, {11'd0, 1'b0, sten, mode[0], mode[1], 1'b0});
    wr(0, 3'd1, 16'(len - 1));
    wr(1, 3'd1, 16'(len - 1));
    wr(0, 3'd2, 16'(baud));
    wr(0, 3'd3, 16'h0001);
    wr(1, 3'd3, 16'h0001);
  endtask

  task automatic wait_done(output int miso_seen);
    logic [15:0] s;
    miso_seen = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(0, 3'd3, s);
      if (p_miso_oe) miso_seen++;
      if (s[0]) break;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic xfer(input string tag, input logic [1:0] mode, input int len, input int baud,
                      input logic [7:0] mt, input logic [7:0] st, input bit mten, input bit sten);
    logic [15:0] v;
    int seen;
    setup(mode, len, baud, mten, sten, 1'b0);
    wr(1, 3'd4, {8'h00, st});
    wr(0, 3'd4, {8'h00, mt});
    wait_done(seen);
    rd(0, 3'd5, v);
    check({tag, " R4 master rx"}, v, {8'h00, exp_rx(st, len, sten)});
    rd(1, 3'd5, v);
    check({tag, " R4 slave rx"}, v, {8'h00, exp_rx(mt, len, mten)});
    check({tag, " R9 idle clock level"}, {15'd0, m_sclk}, {15'd0, mode[1]});
    check({tag, " R8 irq off when disabled"}, {15'd0, m_irq}, 16'd0);
  endtask

  // Master only, mode 0: record line data at rising clock, clock period and select level.
  task automatic observe(input int baud, input logic [7:0] data, input int exp_per);
    logic [7:0] bits = '0;
    logic prev = 1'b0;
    int rises = 0, t0 = 0, t1 = 0, ste_hi = 0, seen;
    setup(2'b00, 8, baud, 1'b1, 1'b1, 1'b0);
    wr(0, 3'd4, {8'h00, data});
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (m_sclk && !prev) begin
        bits = {bits[6:0], line_mosi};
        if (rises == 0) t0 = c;
        if (rises == 1) t1 = c;
        rises++;
        if (m_ste) ste_hi++;
      end
      prev = m_sclk;
      if (rises == 8 && m_ste) break;
    end
    wait_done(seen);
    check("R3 clock period", 16'(t1 - t0), 16'(exp_per));
    check("R1 msb-first line bits", {8'h00, bits}, {8'h00, data});
    check("R9 select low at every edge", 16'(ste_hi), 16'd0);
  endtask

  initial begin
    logic [15:0] v;
    int seen;
    rst_n = 1'b0; ste_block = 1'b0;
    m_addr = '0; p_addr = '0; m_wr = 0; p_wr = 0; m_wd = '0; p_wd = '0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    rd(0, 3'd0, v); check("R9 reset CTRL", v, 16'h0000);
    rd(0, 3'd3, v); check("R8 reset STAT", v, 16'h0000);
    rd(0, 3'd5, v); check("R1 reset RX", v, 16'h0000);
    check("R5 reset outputs off", {14'd0, m_sclk_oe, m_mosi_oe}, 16'd0);

    // Upper byte
    wr(0, 3'd2, 16'hA5C3);
    rd(0, 3'd2, v); check("R7 baud upper byte", v, 16'h0043);
    wr(0, 3'd1, 16'hFF07);
    rd(0, 3'd1, v); check("R7 len upper byte", v, 16'h0007);

    // Divider and bit order
    observe(0,   8'hB4, 4);
    observe(3,   8'h69, 4);
    observe(12,  8'hC3, 13);
    observe(127, 8'h81, 128);

    // Directed: all four modes at full and short lengths
    for (int m = 0; m < 4; m++) begin
      xfer("R2 mode full", 2'(m), 8, 9, 8'hA7, 8'h3C, 1'b1, 1'b1);
      xfer("R2 mode short", 2'(m), 5, 11, 8'hD8, 8'h58, 1'b1, 1'b1);
      xfer("R1 single bit", 2'(m), 1, 10, 8'h80, 8'h00, 1'b1, 1'b1);
    end

    // Transmit disable on either side
    xfer("R5 master tx off", 2'b01, 8, 10, 8'h12, 8'h9E, 1'b0, 1'b1);
    xfer("R5 slave tx off",  2'b10, 6, 10, 8'h5C, 8'h44, 1'b1, 1'b0);

    // Deselected slave
    xfer("R6 prime", 2'b00, 8, 10, 8'h6B, 8'h00, 1'b1, 1'b1);
    ste_block = 1'b1;
    setup(2'b00, 8, 10, 1'b1, 1'b1, 1'b0);
    wr(1, 3'd4, 16'h00F0);
    wr(0, 3'd4, 16'h0011);
    wait_done(seen);
    check("R6 miso never enabled", 16'(seen), 16'd0);
    rd(1, 3'd3, v); check("R6 no completion", {15'd0, v[0]}, 16'd0);
    rd(1, 3'd5, v); check("R6 rx unchanged", v, 16'h006B);
    rd(0, 3'd5, v); check("R6 master sees idle line", v, 16'h00FF);
    ste_block = 1'b0;
    repeat (8) @(negedge clk);

    // Interrupt and write-one-to-clear
    setup(2'b11, 7, 9, 1'b1, 1'b1, 1'b1);
    wr(1, 3'd4, 16'h0022);
    wr(0, 3'd4, 16'h0044);
    check("R8 busy during transfer", {15'd0, m_ste}, 16'd0);
    rd(0, 3'd3, v); check("R8 busy bit", {15'd0, v[1]}, 16'd1);
    wait_done(seen);
    check("R8 irq raised", {15'd0, m_irq}, 16'd1);
    wr(0, 3'd3, 16'h0000);
    rd(0, 3'd3, v); check("R8 write zero keeps flag", v, 16'h0001);
    wr(0, 3'd3, 16'h0001);
    rd(0, 3'd3, v); check("R8 flag cleared", v, 16'h0000);
    check("R8 irq cleared", {15'd0, m_irq}, 16'd0);

    // Random exchanges
    for (int i = 0; i < 24; i++) begin
      logic [1:0] md = 2'($urandom % 4);
      int ln = 1 + int'($urandom % 8);
      int bd = 9 + int'($urandom % 16);
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = 8'($urandom);
      xfer("R2 R4 random", md, ln, bd, a, b, 1'b1, 1'b1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule